// File: doc/BRIEF.md
# Source Route-Switching Injection Controller

This block sits at the injection point of one mesh node. For every packet a local client wants to send, it chooses between the two dimension-ordered routes (X-first or Y-first). It also decides whether that packet closes the current run on its route. Each destination flow keeps its own entry in a small control table. The entry holds the route now in use, the expected run length N, a flag marking that the flow is waiting for an acknowledgement, and the cycle stamps of the last path change and of the last acknowledgement.

A packet closes its run with probability about 1/N, using a pseudo-random value drawn per granted packet. That packet goes out with a switch mark on the old route. The flow's route then flips and the flow is blocked until the destination acknowledges the marked packet. At any moment a flow's packets are therefore on only one path, so they arrive in order without reorder buffers. When the acknowledgement returns, the block releases the flow and emits an update request that carries the measured on and off durations. An external adaptation unit uses these to write a new N back into the table. The destination-side piece of the same protocol is also here: an arriving head flit carrying the switch mark produces a one-flit acknowledgement request aimed at the flow's source.

Top module: `rsw_inject_ctl`

## Requirements
- R1: After synchronous reset every flow is on the X-first route (route bit 0), is not waiting, and has run length N_INIT. Both timestamps are 0, the pseudo-random register holds LFSR_SEED, and grant_valid, stall, upd_valid, ackreq_valid and ack_err are all 0.
- R2: A request for a flow whose waiting flag is set produces stall=1 and grant_valid=0 on the next cycle, and leaves that flow's state unchanged.
- R3: The random value r is a 16-bit shift register. Each step shifts it left by one and inserts into bit 0 the XOR of bits 15, 13, 12 and 10. It steps once per granted request and at no other time. A granted packet carries the switch mark exactly when r·N < 65536, where r is the value before the step and N is the flow's stored run length (N=0 and N=1 always switch).
- R4: A granted packet with the switch mark leaves on the flow's current route; grant_valid, grant_dest, grant_route and grant_switch appear one cycle after the request. The flow's stored route then inverts, its waiting flag is set, and its off stamp takes the cycle input value.
- R5: A granted packet without the switch mark leaves on the current route and changes neither the route nor the waiting flag, so the next request for that flow is granted again.
- R6: An acknowledgement for a waiting flow clears its waiting flag and sets its on stamp to the cycle input value. One cycle later it raises upd_valid with upd_dest equal to the flow, upd_off_time = cycle − off stamp and upd_on_time = off stamp − previous on stamp, both modulo 2^TS_W.
- R7: An acknowledgement for a flow that is not waiting changes no table state and produces no update. It sets ack_err, which stays 1 until reset.
- R8: An N write stores nset_n as the run length of flow nset_dest; later switch decisions for that flow use the new value.
- R9: A head flit with the switch mark raises ackreq_valid for exactly one cycle, one cycle later, with ackreq_dst equal to the flit's source. A head flit without the mark raises nothing.
- R10: Flows are independent: a waiting flow does not stall requests for any other flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle | input | TS_W | Free-running cycle count used for stamps |
| req_valid | input | 1 | Injection request |
| req_dest | input | D_W | Flow (destination index) of the request |
| nset_valid | input | 1 | Run-length write strobe from the adaptation unit |
| nset_dest | input | D_W | Flow whose run length is written |
| nset_n | input | N_W | New run length |
| ack_valid | input | 1 | Acknowledgement packet arrived at this source |
| ack_dest | input | D_W | Flow the acknowledgement belongs to |
| rx_head_valid | input | 1 | Head flit arriving at this node as destination |
| rx_switch | input | 1 | Switch mark of that head flit |
| rx_src | input | NODE_W | Source node of that head flit |
| grant_valid | output | 1 | Packet may be injected |
| grant_dest | output | D_W | Flow of the granted packet |
| grant_route | output | 1 | Route: 0 X-first, 1 Y-first |
| grant_switch | output | 1 | Switch mark for the granted packet |
| stall | output | 1 | Request refused; flow waits for acknowledgement |
| upd_valid | output | 1 | Run-length update request |
| upd_dest | output | D_W | Flow of the update request |
| upd_on_time | output | TS_W | Length of the last on period |
| upd_off_time | output | TS_W | Length of the last off period |
| ack_err | output | 1 | Sticky flag: acknowledgement for a non-waiting flow |
| ackreq_valid | output | 1 | Send a one-flit acknowledgement |
| ackreq_dst | output | NODE_W | Node the acknowledgement is sent to |

## Verification
On every cycle, the assertions check the local implications: grant and stall never coincide, a switch mark only rides on a grant, every grant, update and acknowledgement request traces back to an input one cycle earlier, and the error flag never falls outside reset. Whether the chosen route, the random switch decision, the stall of a waiting flow and the measured durations are right depends on state built up over many packets. Only the bench's sweeps can show this, because it compares each response against an arithmetic model of the table and the shift register across several run lengths and all flows.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  typedef enum logic {
    ROUTE_XY = 1'b0,
    ROUTE_YX = 1'b1
  } route_e;
endpackage

// File: rtl/rsw_lfsr.sv
module rsw_lfsr #(
  parameter int R_W = 16,
  parameter logic [R_W-1:0] SEED = 16'hACE1,
  parameter logic [R_W-1:0] TAPS = 16'hB400
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  output logic [R_W-1:0] value
);
  logic fb;
  assign fb = ^(value & TAPS);

  always_ff @(posedge clk) begin
    if (rst)      value <= SEED;
    else if (adv) value <= {value[R_W-2:0], fb};
  end
endmodule

// File: rtl/rsw_route_table.sv
module rsw_route_table
  import rsw_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int D_W     = 3,
  parameter int N_W     = 15,
  parameter int TS_W    = 16,
  parameter int N_INIT  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TS_W-1:0] now,
  // port A: request side
  input  logic [D_W-1:0]  a_addr,
  output route_e          a_route,
  output logic            a_wait,
  output logic [N_W-1:0]  a_n,
  input  logic            a_switch_we,
  // port B: acknowledgement side
  input  logic [D_W-1:0]  b_addr,
  output logic            b_wait,
  output logic [TS_W-1:0] b_on_ts,
  output logic [TS_W-1:0] b_off_ts,
  input  logic            b_ack_we,
  // run-length write
  input  logic            n_we,
  input  logic [D_W-1:0]  n_addr,
  input  logic [N_W-1:0]  n_val
);
  route_e          route_q [ENTRIES];
  logic            wait_q  [ENTRIES];
  logic [N_W-1:0]  n_q     [ENTRIES];
  logic [TS_W-1:0] on_q    [ENTRIES];
  logic [TS_W-1:0] off_q   [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic hit_sw, hit_ack, hit_n;
    assign hit_sw  = a_switch_we && (a_addr == D_W'(i));
    assign hit_ack = b_ack_we    && (b_addr == D_W'(i));
    assign hit_n   = n_we        && (n_addr == D_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        route_q[i] <= ROUTE_XY;
        wait_q[i]  <= 1'b0;
        n_q[i]     <= N_W'(N_INIT);
        on_q[i]    <= '0;
        off_q[i]   <= '0;
      end else begin
        if (hit_sw) begin
          route_q[i] <= (route_q[i] == ROUTE_XY) ? ROUTE_YX : ROUTE_XY;
          wait_q[i]  <= 1'b1;
          off_q[i]   <= now;
        end else if (hit_ack) begin
          wait_q[i]  <= 1'b0;
          on_q[i]    <= now;
        end
        if (hit_n) n_q[i] <= n_val;
      end
    end
  end

  assign a_route  = route_q[a_addr];
  assign a_wait   = wait_q[a_addr];
  assign a_n      = n_q[a_addr];
  assign b_wait   = wait_q[b_addr];
  assign b_on_ts  = on_q[b_addr];
  assign b_off_ts = off_q[b_addr];
endmodule

// File: rtl/rsw_ack_gen.sv
module rsw_ack_gen #(
  parameter int NODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic              switch_bit,
  input  logic [NODE_W-1:0] src,
  output logic              out_valid,
  output logic [NODE_W-1:0] out_dst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dst   <= '0;
    end else begin
      out_valid <= head_valid && switch_bit;
      out_dst   <= src;
    end
  end
endmodule

// File: rtl/rsw_inject_ctl.sv
module rsw_inject_ctl
  import rsw_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int N_W     = 15,
  parameter int TS_W    = 16,
  parameter int NODE_W  = 6,
  parameter int R_W     = 16,
  parameter int N_INIT  = 4,
  parameter logic [R_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [R_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int D_W    = $clog2(ENTRIES),
  localparam int P_W    = R_W + N_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   cycle,
  input  logic              req_valid,
  input  logic [D_W-1:0]    req_dest,
  input  logic              nset_valid,
  input  logic [D_W-1:0]    nset_dest,
  input  logic [N_W-1:0]    nset_n,
  input  logic              ack_valid,
  input  logic [D_W-1:0]    ack_dest,
  input  logic              rx_head_valid,
  input  logic              rx_switch,
  input  logic [NODE_W-1:0] rx_src,
  output logic              grant_valid,
  output logic [D_W-1:0]    grant_dest,
  output logic              grant_route,
  output logic              grant_switch,
  output logic              stall,
  output logic              upd_valid,
  output logic [D_W-1:0]    upd_dest,
  output logic [TS_W-1:0]   upd_on_time,
  output logic [TS_W-1:0]   upd_off_time,
  output logic              ack_err,
  output logic              ackreq_valid,
  output logic [NODE_W-1:0] ackreq_dst
);
  route_e          a_route;
  logic            a_wait, b_wait;
  logic [N_W-1:0]  a_n;
  logic [TS_W-1:0] b_on_ts, b_off_ts;
  logic [R_W-1:0]  rnd;
  logic [P_W-1:0]  prod;
  logic            grant_now, switch_now, ack_ok, ack_bad;

  // switch when r*N < 2^R_W, i.e. r/2^R_W < 1/N
  assign prod       = P_W'(rnd) * P_W'(a_n);
  assign grant_now  = req_valid && !a_wait;
  assign switch_now = grant_now && ~|prod[P_W-1:R_W];
  assign ack_ok     = ack_valid && b_wait;
  assign ack_bad    = ack_valid && !b_wait;

  rsw_lfsr #(.R_W(R_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .adv   (grant_now),
    .value (rnd)
  );

  rsw_route_table #(
    .ENTRIES(ENTRIES), .D_W(D_W), .N_W(N_W), .TS_W(TS_W), .N_INIT(N_INIT)
  ) u_tbl (
    .clk         (clk),
    .rst         (rst),
    .now         (cycle),
    .a_addr      (req_dest),
    .a_route     (a_route),
    .a_wait      (a_wait),
    .a_n         (a_n),
    .a_switch_we (switch_now),
    .b_addr      (ack_dest),
    .b_wait      (b_wait),
    .b_on_ts     (b_on_ts),
    .b_off_ts    (b_off_ts),
    .b_ack_we    (ack_ok),
    .n_we        (nset_valid),
    .n_addr      (nset_dest),
    .n_val       (nset_n)
  );

  rsw_ack_gen #(.NODE_W(NODE_W)) u_ackgen (
    .clk        (clk),
    .rst        (rst),
    .head_valid (rx_head_valid),
    .switch_bit (rx_switch),
    .src        (rx_src),
    .out_valid  (ackreq_valid),
    .out_dst    (ackreq_dst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid  <= 1'b0;
      grant_dest   <= '0;
      grant_route  <= 1'b0;
      grant_switch <= 1'b0;
      stall        <= 1'b0;
      upd_valid    <= 1'b0;
      upd_dest     <= '0;
      upd_on_time  <= '0;
      upd_off_time <= '0;
      ack_err      <= 1'b0;
    end else begin
      grant_valid  <= grant_now;
      grant_dest   <= req_dest;
      grant_route  <= a_route;
      grant_switch <= switch_now;
      stall        <= req_valid && a_wait;
      upd_valid    <= ack_ok;
      upd_dest     <= ack_dest;
      upd_on_time  <= b_off_ts - b_on_ts;
      upd_off_time <= cycle - b_off_ts;
      if (ack_bad) ack_err <= 1'b1;
    end
  end
endmodule

// File: rtl/rsw_inject_chk.sv
module rsw_inject_chk #(
  parameter int D_W    = 3,
  parameter int NODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              ack_valid,
  input logic              rx_head_valid,
  input logic              rx_switch,
  input logic              grant_valid,
  input logic              grant_switch,
  input logic              stall,
  input logic              upd_valid,
  input logic              ack_err,
  input logic              ackreq_valid
);
  // R2: a refused request never also gets a grant
  a_r2_grant_xor_stall: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && stall));

  // R2: grants and stalls answer a request from the previous cycle
  a_r2_answer_has_req: assert property (@(posedge clk) disable iff (rst)
    (grant_valid || stall) |-> $past(req_valid));

  // R4: the switch mark only travels with a grant
  a_r4_switch_on_grant: assert property (@(posedge clk) disable iff (rst)
    grant_switch |-> grant_valid);

  // R6: an update request follows an acknowledgement
  a_r6_upd_after_ack: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $past(ack_valid));

  // R7: the error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    ack_err |=> ack_err);

  // R9: an acknowledgement request follows a marked head flit
  a_r9_ackreq_cause: assert property (@(posedge clk) disable iff (rst)
    ackreq_valid |-> $past(rx_head_valid && rx_switch));
endmodule

bind rsw_inject_ctl rsw_inject_chk #(.D_W(D_W), .NODE_W(NODE_W)) u_chk (.*);

// File: tb/sim_rsw_inject_ctl.sv
module sim_rsw_inject_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 4;
  localparam int D_W = 2;
  localparam int N_W = 15;
  localparam int TS_W = 16;
  localparam int NODE_W = 6;
  localparam int N_INIT = 4;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TS_W-1:0] cycle;
  logic req_valid = 0, nset_valid = 0, ack_valid = 0;
  logic [D_W-1:0] req_dest = 0, nset_dest = 0, ack_dest = 0;
  logic [N_W-1:0] nset_n = 0;
  logic rx_head_valid = 0, rx_switch = 0;
  logic [NODE_W-1:0] rx_src = 0;
  logic grant_valid, grant_route, grant_switch, stall, upd_valid, ack_err, ackreq_valid;
  logic [D_W-1:0] grant_dest, upd_dest;
  logic [TS_W-1:0] upd_on_time, upd_off_time;
  logic [NODE_W-1:0] ackreq_dst;

  int cyc = 0;
  int nchk = 0, nerr = 0;
  logic done = 0;

  // bench model
  logic        m_route [ENTRIES];
  logic        m_wait  [ENTRIES];
  int          m_n     [ENTRIES];
  logic [15:0] m_on    [ENTRIES];
  logic [15:0] m_off   [ENTRIES];
  logic [15:0] m_lfsr;

  assign cycle = TS_W'(cyc);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  rsw_inject_ctl #(.ENTRIES(ENTRIES), .N_W(N_W), .TS_W(TS_W), .NODE_W(NODE_W),
                   .N_INIT(N_INIT), .LFSR_SEED(SEED)) u0 (.*);

  function automatic logic [15:0] lfsr_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int d);
    longint prod;
    bit sw;
    @(negedge clk); req_valid = 1; req_dest = D_W'(d);
    @(posedge clk); #1;
    if (m_wait[d]) begin
      check("R2 stall", stall, 1);
      check("R2 no grant", grant_valid, 0);
    end else begin
      prod = longint'(m_lfsr) * longint'(m_n[d]);
      sw = (prod < 65536);
      check("R5 grant", grant_valid, 1);
      check("R10 no stall", stall, 0);
      check("R4 dest", grant_dest, d);
      check("R4 route", grant_route, m_route[d]);
      check("R3 switch mark", grant_switch, sw);
      m_lfsr = lfsr_step(m_lfsr);
      if (sw) begin
        m_route[d] = ~m_route[d];
        m_wait[d] = 1;
        m_off[d] = 16'(cyc);
      end
    end
    @(negedge clk); req_valid = 0;
  endtask

  task automatic do_ack(input int d);
    @(negedge clk); ack_valid = 1; ack_dest = D_W'(d);
    @(posedge clk); #1;
    if (m_wait[d]) begin
      check("R6 upd valid", upd_valid, 1);
      check("R6 upd dest", upd_dest, d);
      check("R6 off time", upd_off_time, 16'(16'(cyc) - m_off[d]));
      check("R6 on time", upd_on_time, 16'(m_off[d] - m_on[d]));
      m_wait[d] = 0;
      m_on[d] = 16'(cyc);
    end else begin
      check("R7 no upd", upd_valid, 0);
      check("R7 err set", ack_err, 1);
    end
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic do_nset(input int d, input int n);
    @(negedge clk); nset_valid = 1; nset_dest = D_W'(d); nset_n = N_W'(n);
    @(posedge clk); m_n[d] = n;
    @(negedge clk); nset_valid = 0;
  endtask

  task automatic do_rx(input bit sw, input int src);
    @(negedge clk); rx_head_valid = 1; rx_switch = sw; rx_src = NODE_W'(src);
    @(posedge clk); #1;
    check("R9 ackreq", ackreq_valid, sw);
    if (sw) check("R9 ackreq dst", ackreq_dst, src);
    @(negedge clk); rx_head_valid = 0; rx_switch = 0;
    @(posedge clk); #1;
    check("R9 single pulse", ackreq_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : main
    int nvals [7] = '{0, 1, 2, 3, 5, 8, 40};
    for (int i = 0; i < ENTRIES; i++) begin
      m_route[i] = 0; m_wait[i] = 0; m_n[i] = N_INIT; m_on[i] = 0; m_off[i] = 0;
    end
    m_lfsr = SEED;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    // R1 reset state at the ports
    check("R1 grant", grant_valid, 0);
    check("R1 stall", stall, 0);
    check("R1 upd", upd_valid, 0);
    check("R1 ackreq", ackreq_valid, 0);
    check("R1 err", ack_err, 0);
    // R1: first request of every flow uses X-first route with N_INIT
    for (int d = 0; d < ENTRIES; d++) begin
      do_req(d);
      if (m_wait[d]) do_ack(d);
    end

    // sweep run lengths over all flows (R3 R4 R5 R6 R8 R10)
    foreach (nvals[k]) begin
      for (int d = 0; d < ENTRIES; d++) begin
        do_nset(d, nvals[k]);
        for (int j = 0; j < 200; j++) begin
          do_req(d);
          if (m_wait[d]) break;
        end
        if (m_wait[d]) begin
          do_req(d);                     // R2: stalled while waiting
          do_req((d + 1) % ENTRIES);     // R10: other flow unaffected
          repeat (d + 2) @(posedge clk);
          do_ack(d);
          do_req(d);                     // R6: released again
        end
        for (int o = 0; o < ENTRIES; o++)
          if (m_wait[o]) do_ack(o);
      end
    end
    check("R7 no error yet", ack_err, 0);

    // R7: stray acknowledgement
    do_ack(2);
    do_req(2);                           // state unchanged
    if (m_wait[2]) do_ack(2);
    do_ack(1);
    check("R7 sticky", ack_err, 1);

    // R9: destination side
    for (int s = 0; s < 64; s += 9) begin
      do_rx(1, s);
      do_rx(0, s + 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule